// File: doc/BRIEF.md
# SPI Transfer Sequence Controller

This block executes one atomic SPI message. A message is a list of transfer descriptors, loaded ahead of time into a small descriptor buffer. The block does not shift bits itself. It hands whole words to an external word-level shift engine and collects the words that engine receives. Each descriptor gives four things: how many words to move, which direction the data flows, how long to wait afterwards, and whether chip select should be released.

The block streams transmit words in from a valid/ready source and streams received words out to a valid/ready sink. It drives the active-low chip select across the whole message. At the end it emits a single completion pulse that carries an error flag.

To use it, write descriptors at buffer addresses 0..N-1. Then pulse `msg_start` with `msg_last_idx` = N-1. The block ignores `msg_start` while it is busy. A message that ends with cs_change set on its final descriptor leaves the device selected. This lets a follow-on message to the same device skip the deselect/select cost.

Top module: `spi_seq_ctrl`

## Requirements
- R1: The descriptor word is laid out as follows:
  - bits [CNT_W-1:0] hold the word count;
  - the next DLY_W bits hold the delay in clock cycles;
  - the next 2 bits hold the direction (0 full duplex, 1 write only, 2 read only);
  - the top bit holds cs_change.
  Descriptors 0..`msg_last_idx` execute strictly in ascending order, and their words reach the engine in that order.
- R2: In a full-duplex descriptor, each word accepted on the tx port is handed to the engine with an `eng_go` pulse. Each word the engine returns is offered on the rx port.
- R3: In a write-only descriptor, the word returned by the engine is discarded and `rx_valid` never rises.
- R4: In a read-only descriptor, `tx_ready` stays low and the engine receives all-zero words.
- R5: After a descriptor's last word, the block waits at least the descriptor's delay in cycles before it starts the next descriptor or completes the message.
- R6: A descriptor with a zero word count produces only its delay, with no `eng_go` pulse.
- R7: Chip select (`spi_cs_n`, active low) stays asserted across descriptor boundaries unless cs_change is set, and it is asserted whenever `eng_go` pulses.
- R8: When cs_change is set on a descriptor that is not the last, `spi_cs_n` goes high after that descriptor's delay. It stays high for at least CS_GAP cycles and then goes low again before the next descriptor runs.
- R9: On the final descriptor the meaning of cs_change is reversed:
  - when set, `spi_cs_n` stays low after completion;
  - when clear, `spi_cs_n` is high from the completion pulse onward.
- R10: An error ends the message, deasserts chip select and abandons the remaining descriptors. An error is raised when either of these stalls lasts TIMEOUT cycles:
  - a needed transmit word is not offered;
  - an offered receive word is not accepted.
- R11: Each started message produces exactly one one-cycle `msg_done` pulse. `msg_err` is 1 on that pulse for an error and 0 for success.
- R12: After reset, `spi_cs_n` is 1 and `busy`, `msg_done`, `tx_ready`, `rx_valid` and `eng_go` are 0.
- R13: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` holds its value, unless the timeout ends the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor buffer write enable |
| desc_addr | input | AW | Descriptor buffer write address |
| desc_wdata | input | DESC_W | Descriptor word (layout in R1) |
| msg_start | input | 1 | Start a message (ignored while busy) |
| msg_last_idx | input | AW | Index of the final descriptor |
| busy | output | 1 | A message is in progress |
| msg_done | output | 1 | One-cycle completion pulse |
| msg_err | output | 1 | Error status, valid with msg_done |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DATA_W | Transmit word |
| tx_ready | output | 1 | Transmit word accepted when high with tx_valid |
| rx_valid | output | 1 | Received word offered |
| rx_data | output | DATA_W | Received word |
| rx_ready | input | 1 | Sink accepts received word |
| eng_go | output | 1 | Start one word on the shift engine |
| eng_tx | output | DATA_W | Word for the engine to send |
| eng_done | input | 1 | Engine finished the word |
| eng_rx | input | DATA_W | Word the engine received |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the block with DEPTH 4, TIMEOUT 20 and CS_GAP 3. This keeps three-descriptor messages within a small buffer and lets both timeout error paths trigger within a few dozen cycles. It also makes the release window between transfers short enough to measure exactly while still being wider than one cycle. The shift engine model answers each word with its complement two cycles later. From that, the scoreboard derives every expected engine word and every expected received word. The rx sink runs in three modes: always ready, never ready, and alternating, which exercises both normal backpressure and the stall error.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    DIR_FULL = 2'd0,
    DIR_WR   = 2'd1,
    DIR_RD   = 2'd2,
    DIR_RSVD = 2'd3
  } xfer_dir_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_TXW,
    ST_ENGW,
    ST_RXW,
    ST_DELAY,
    ST_GAP
  } seq_state_e;

endpackage

// File: rtl/spi_seq_desc_ram.sv
module spi_seq_desc_ram #(
  parameter int WIDTH = 19,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Synchronous write and registered read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_seq_wait_timer.sv
module spi_seq_wait_timer #(
  parameter int LIMIT = 64,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || clr) begin
      cnt <= '0;
    end else if (cnt != TW'(LIMIT - 1)) begin
      cnt <= cnt + TW'(1);
    end
  end

  assign expired = run && !clr && (cnt == TW'(LIMIT - 1));

  // Saturates at the limit and never exceeds it.
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(LIMIT - 1));

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 8,
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 64,
  parameter int CS_GAP  = 4,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DESC_W = CNT_W + DLY_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_we,
  input  logic [AW-1:0]     desc_addr,
  input  logic [DESC_W-1:0] desc_wdata,
  input  logic              msg_start,
  input  logic [AW-1:0]     msg_last_idx,
  output logic              busy,
  output logic              msg_done,
  output logic              msg_err,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              eng_go,
  output logic [DATA_W-1:0] eng_tx,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rx,
  output logic              spi_cs_n
);

  localparam int DLY_LSB = CNT_W;
  localparam int DIR_LSB = CNT_W + DLY_W;
  localparam int CHG_BIT = CNT_W + DLY_W + 2;
  localparam int GAP_W   = $clog2(CS_GAP + 1);

  seq_state_e        state;
  logic [AW-1:0]     idx, last_idx;
  logic [CNT_W-1:0]  words_left;
  logic [DLY_W-1:0]  dly_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  xfer_dir_e         cur_dir;
  logic              cur_chg;
  logic              cs_sel;
  logic              go_q, done_q, err_q;
  logic [DATA_W-1:0] tx_word_q, rx_word_q;
  logic [DESC_W-1:0] rd_q;
  logic              tmo_run, tmo_clr, tmo_hit;
  logic              tx_fire, rx_fire;

  spi_seq_desc_ram #(.WIDTH(DESC_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (desc_we),
    .waddr (desc_addr),
    .wdata (desc_wdata),
    .raddr (idx),
    .rdata (rd_q)
  );

  assign tx_ready = (state == ST_TXW) && (cur_dir != DIR_RD);
  assign rx_valid = (state == ST_RXW);
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_fire  = rx_valid && rx_ready;
  assign tmo_run  = tx_ready || rx_valid;
  assign tmo_clr  = tx_fire || rx_fire;

  spi_seq_wait_timer #(.LIMIT(TIMEOUT)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (tmo_run),
    .clr     (tmo_clr),
    .expired (tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      last_idx   <= '0;
      words_left <= '0;
      dly_cnt    <= '0;
      gap_cnt    <= '0;
      cur_dir    <= DIR_FULL;
      cur_chg    <= 1'b0;
      cs_sel     <= 1'b0;
      go_q       <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      tx_word_q  <= '0;
      rx_word_q  <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (msg_start) begin
            idx      <= '0;
            last_idx <= msg_last_idx;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          words_left <= rd_q[CNT_W-1:0];
          dly_cnt    <= rd_q[DLY_LSB +: DLY_W];
          cur_dir    <= xfer_dir_e'(rd_q[DIR_LSB +: 2]);
          cur_chg    <= rd_q[CHG_BIT];
          cs_sel     <= 1'b1;
          state      <= (rd_q[CNT_W-1:0] == '0) ? ST_DELAY : ST_TXW;
        end
        ST_TXW: begin
          if (cur_dir == DIR_RD) begin
            tx_word_q <= '0;
            go_q      <= 1'b1;
            state     <= ST_ENGW;
          end else if (tx_valid) begin
            tx_word_q <= tx_data;
            go_q      <= 1'b1;
            state     <= ST_ENGW;
          end else if (tmo_hit) begin
            cs_sel <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_ENGW: begin
          if (eng_done) begin
            if (cur_dir == DIR_WR) begin
              words_left <= words_left - CNT_W'(1);
              state      <= (words_left == CNT_W'(1)) ? ST_DELAY : ST_TXW;
            end else begin
              rx_word_q <= eng_rx;
              state     <= ST_RXW;
            end
          end
        end
        ST_RXW: begin
          if (rx_ready) begin
            words_left <= words_left - CNT_W'(1);
            state      <= (words_left == CNT_W'(1)) ? ST_DELAY : ST_TXW;
          end else if (tmo_hit) begin
            cs_sel <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_DELAY: begin
          if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end else if (idx == last_idx) begin
            // On the final descriptor a set cs_change keeps the device selected.
            cs_sel <= cur_chg;
            done_q <= 1'b1;
            err_q  <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            idx <= idx + AW'(1);
            if (cur_chg) begin
              cs_sel  <= 1'b0;
              gap_cnt <= GAP_W'(CS_GAP - 1);
              state   <= ST_GAP;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == '0) state <= ST_FETCH;
          else               gap_cnt <= gap_cnt - GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign msg_done = done_q;
  assign msg_err  = err_q;
  assign eng_go   = go_q;
  assign eng_tx   = tx_word_q;
  assign rx_data  = rx_word_q;
  assign spi_cs_n = !cs_sel;

  // Checker state: cycles chip select has been released, saturating.
  logic [GAP_W-1:0] off_cnt;
  always_ff @(posedge clk) begin
    if (rst)                          off_cnt <= GAP_W'(CS_GAP);
    else if (!spi_cs_n)               off_cnt <= '0;
    else if (off_cnt != GAP_W'(CS_GAP)) off_cnt <= off_cnt + GAP_W'(1);
  end

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    msg_done |=> !msg_done);

  p_err_cs_off_r10: assert property (@(posedge clk) disable iff (rst)
    (msg_done && msg_err) |-> spi_cs_n);

  p_go_with_cs_r7: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> !spi_cs_n);

  p_wr_no_rx_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_dir == DIR_WR && state != ST_DECODE) |-> !rx_valid);

  p_rx_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !tmo_hit) |=> (rx_valid && $stable(rx_data)));

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(spi_cs_n) && idx != '0) |-> (off_cnt >= GAP_W'(CS_GAP)));

endmodule

// File: tb/spi_seq_ctrl_bench.sv
`timescale 1ns/1ps
module spi_seq_ctrl_bench;

  localparam int DATA_W = 8, CNT_W = 8, DLY_W = 8, DEPTH = 4;
  localparam int TIMEOUT = 20, CS_GAP = 3;
  localparam int AW = 2, DESC_W = CNT_W + DLY_W + 3;

  logic clk = 1'b0, rst = 1'b1;
  logic desc_we = 1'b0;
  logic [AW-1:0] desc_addr = '0;
  logic [DESC_W-1:0] desc_wdata = '0;
  logic msg_start = 1'b0;
  logic [AW-1:0] msg_last_idx = '0;
  logic busy, msg_done, msg_err;
  logic tx_valid = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ready;
  logic [DATA_W-1:0] rx_data;
  logic eng_go, eng_done = 1'b0;
  logic [DATA_W-1:0] eng_tx, eng_rx = '0;
  logic spi_cs_n;

  always #2.5 clk = ~clk;

  spi_seq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .DEPTH(DEPTH),
                 .TIMEOUT(TIMEOUT), .CS_GAP(CS_GAP)) u_spi_seq_ctrl (
    .clk(clk), .rst(rst), .desc_we(desc_we), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .msg_start(msg_start), .msg_last_idx(msg_last_idx),
    .busy(busy), .msg_done(msg_done), .msg_err(msg_err),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .eng_go(eng_go), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx),
    .spi_cs_n(spi_cs_n));

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] exp_eng[$], exp_rx[$], src_tx[$];
  int go_cnt, tx_cnt, rx_cnt, done_cnt, cs_rise_cnt, min_gap;
  int rx_mode = 0;       // 0 always ready, 1 never, 2 alternate
  bit in_msg = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DESC_W-1:0] mk(int cnt, int dly, int dir, bit chg);
    return {chg, 2'(dir), DLY_W'(dly), CNT_W'(cnt)};
  endfunction

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  // Engine model and monitor of engine words (R1, R2, R4)
  initial begin
    int pend = 0;
    logic [DATA_W-1:0] last_tx = '0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin eng_done = 1'b1; eng_rx = ~last_tx; end
      end
      if (!rst && eng_go) begin
        go_cnt++;
        if (exp_eng.size() == 0) chk(0, "R1 unexpected engine word", int'(eng_tx), -1);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_eng.pop_front();
          chk(eng_tx == e, "R1/R2/R4 engine word", int'(eng_tx), int'(e));
        end
        last_tx = eng_tx;
        pend = 2;
      end
    end
  end

  // Transmit source
  initial begin
    bit fired = 0;
    forever begin
      @(negedge clk);
      if (fired) begin
        void'(src_tx.pop_front());
        tx_cnt++;
      end
      tx_valid = (src_tx.size() != 0);
      tx_data  = tx_valid ? src_tx[0] : '0;
      fired = tx_valid && tx_ready;
    end
  end

  // Receive sink and scoreboard (R2, R13)
  initial begin
    bit tog = 0;
    bit held = 0;
    logic [DATA_W-1:0] held_d = '0;
    forever begin
      @(negedge clk);
      if (held && !msg_done)
        chk(rx_valid && rx_data == held_d, "R13 rx held while stalled", int'(rx_data), int'(held_d));
      tog = !tog;
      rx_ready = (rx_mode == 0) ? 1'b1 : (rx_mode == 1) ? 1'b0 : tog;
      held = rx_valid && !rx_ready;
      held_d = rx_data;
      if (rx_valid && rx_ready) begin
        rx_cnt++;
        if (exp_rx.size() == 0) chk(0, "R3 unexpected rx word", int'(rx_data), -1);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R2 rx word", int'(rx_data), int'(e));
        end
      end
    end
  end

  // Chip select and done monitor (R7, R8, R11)
  initial begin
    logic prev = 1'b1;
    bit meas = 0;
    int run = 0;
    forever begin
      @(negedge clk);
      if (msg_done) done_cnt++;
      if (in_msg && spi_cs_n && !prev && !msg_done) begin
        cs_rise_cnt++; meas = 1; run = 0;
      end
      if (meas) begin
        if (spi_cs_n) run++;
        else begin
          if (run < min_gap) min_gap = run;
          meas = 0;
        end
      end
      prev = spi_cs_n;
    end
  end

  task automatic load(input int i, input logic [DESC_W-1:0] d);
    @(negedge clk);
    desc_we = 1'b1; desc_addr = AW'(i); desc_wdata = d;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  // Run a loaded message and return status, cs level after done and cycle count
  task automatic run_msg(input int last, output bit err, output bit cs_n_end, output int cycles);
    int t = 0;
    go_cnt = 0; tx_cnt = 0; rx_cnt = 0; done_cnt = 0; cs_rise_cnt = 0; min_gap = 1000;
    @(negedge clk);
    in_msg = 1;
    msg_last_idx = AW'(last);
    msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    while (!msg_done && t < 3000) begin @(negedge clk); t++; end
    err = msg_err; cs_n_end = spi_cs_n; cycles = t + 1;
    in_msg = 0;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R11 one done pulse", done_cnt, 1);
  endtask

  initial begin
    bit err, csn;
    int cyc_m;
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(spi_cs_n == 1'b1, "R12 cs_n in reset", int'(spi_cs_n), 1);
    chk(!busy && !msg_done && !tx_ready && !rx_valid && !eng_go, "R12 idle outputs",
        int'({busy, msg_done, tx_ready, rx_valid, eng_go}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1'b1 && !busy, "R12 after reset", int'({spi_cs_n, busy}), 2);

    // M1: full duplex, write only, read only, no cs_change (R1..R4, R7)
    load(0, mk(3, 2, 0, 0));
    load(1, mk(2, 0, 1, 0));
    load(2, mk(2, 1, 2, 0));
    src_tx = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    exp_eng = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h00, 8'h00};
    exp_rx = '{8'hEE, 8'hDD, 8'hCC, 8'hFF, 8'hFF};
    run_msg(2, err, csn, cyc_m);
    chk(!err, "R11 M1 status ok", int'(err), 0);
    chk(go_cnt == 7, "R1 M1 engine words", go_cnt, 7);
    chk(tx_cnt == 5, "R4 M1 no tx taken in read-only", tx_cnt, 5);
    chk(rx_cnt == 5, "R3 M1 write-only rx discarded", rx_cnt, 5);
    chk(exp_eng.size() == 0 && exp_rx.size() == 0, "R2 M1 scoreboard drained",
        exp_eng.size() + exp_rx.size(), 0);
    chk(cs_rise_cnt == 0, "R7 M1 cs held across descriptors", cs_rise_cnt, 0);
    chk(csn == 1'b1, "R9 M1 cs released at end", int'(csn), 1);

    // M2: cs_change mid-message, delay-only, cs_change on last (R6, R8, R9)
    load(0, mk(1, 0, 0, 1));
    load(1, mk(0, 6, 0, 0));
    load(2, mk(1, 0, 1, 1));
    src_tx = '{8'h5A, 8'h3C};
    exp_eng = '{8'h5A, 8'h3C};
    exp_rx = '{8'hA5};
    run_msg(2, err, csn, cyc_m);
    chk(!err, "R11 M2 status ok", int'(err), 0);
    chk(go_cnt == 2, "R6 M2 delay-only has no engine word", go_cnt, 2);
    chk(cs_rise_cnt == 1, "R8 M2 one cs release", cs_rise_cnt, 1);
    chk(min_gap >= CS_GAP, "R8 M2 release width", min_gap, CS_GAP);
    chk(csn == 1'b0, "R9 M2 cs kept after last cs_change", int'(csn), 0);
    chk(spi_cs_n == 1'b0, "R9 M2 cs still kept while idle", int'(spi_cs_n), 0);

    // M3: delay-only message (R5, R6)
    load(0, mk(0, 12, 0, 0));
    run_msg(0, err, csn, cyc_m);
    chk(go_cnt == 0, "R6 M3 no engine activity", go_cnt, 0);
    chk(cyc_m >= 12, "R5 M3 delay respected", cyc_m, 12);
    chk(csn == 1'b1 && !err, "R9 M3 cs released, ok", int'({csn, err}), 2);

    // M4: receive sink stall -> error, rest abandoned (R10)
    load(0, mk(1, 0, 0, 0));
    load(1, mk(2, 0, 1, 0));
    src_tx = '{8'h77, 8'h88, 8'h99};
    exp_eng = '{8'h77};
    exp_rx = '{8'h88};
    rx_mode = 1;
    run_msg(1, err, csn, cyc_m);
    rx_mode = 0;
    chk(err == 1'b1, "R10 M4 rx stall error", int'(err), 1);
    chk(csn == 1'b1, "R10 M4 cs released on error", int'(csn), 1);
    chk(go_cnt == 1, "R10 M4 later descriptor abandoned", go_cnt, 1);
    src_tx.delete(); exp_rx.delete(); exp_eng.delete();

    // M5: transmit underrun -> error (R10)
    load(0, mk(2, 0, 0, 0));
    src_tx = '{8'h01};
    exp_eng = '{8'h01};
    exp_rx = '{8'hFE};
    run_msg(0, err, csn, cyc_m);
    chk(err == 1'b1, "R10 M5 underrun error", int'(err), 1);
    chk(csn == 1'b1 && go_cnt == 1, "R10 M5 cs off, one word", int'({csn, 3'(go_cnt)}), 9);
    src_tx.delete(); exp_rx.delete(); exp_eng.delete();

    // M6: recovery with receive backpressure (R2, R13)
    load(0, mk(4, 1, 0, 0));
    src_tx = '{8'hA0, 8'hB1, 8'hC2, 8'hD3};
    exp_eng = '{8'hA0, 8'hB1, 8'hC2, 8'hD3};
    exp_rx = '{8'h5F, 8'h4E, 8'h3D, 8'h2C};
    rx_mode = 2;
    run_msg(0, err, csn, cyc_m);
    rx_mode = 0;
    chk(!err, "R11 M6 status ok", int'(err), 0);
    chk(rx_cnt == 4 && exp_rx.size() == 0, "R2 M6 all rx under backpressure", rx_cnt, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule